// File: doc/BRIEF.md
# Transceiver Recalibration Sequencer

This block drives a recalibration of a transceiver's analog front end entirely over a memory-mapped register bus with a wait-request handshake. A one-cycle `start` pulse arrives with option bits. These select whether the receive path, the transmit path or both are recalibrated, whether a data-rate switch took place, and which of the two calibration-busy indications should be enabled.

The sequencer first takes the configuration bus away from the on-chip calibration engine. It polls a capability register until the arbitration bit clears. It then applies read-modify-write updates to the calibration-enable register, the rate-switch flag register (only for a receive recalibration) and the busy-enable bits of the capability register. After that it hands the bus back to the engine. Finally it reads the status bits at a programmable spacing until every enabled busy flag is low, and then pulses `done`. A timeout limit covers the two waiting phases. If the limit is reached, `error` pulses and the block returns to idle.

Register addresses (12-bit): ownership 0x000, calibration enable 0x100, rate-switch flags 0x166, capability/status 0x281.

Top module: `xcvr_recal_seq`

## Requirements
- R1: Each bus access keeps address, read strobe, write strobe and write data unchanged while `bus_waitreq` is high. Read data is captured on the edge where the strobe is high and `bus_waitreq` is low. Read and write are never high together.
- R2: The first access after an accepted start writes 0x00000002 to address 0x000 to claim the bus.
- R3: Address 0x281 is then read again and again until bit 2 reads 0. No other register is accessed before that.
- R4: Address 0x100 is read and then written back with bit 6 cleared, bit 1 set if RX was selected and bit 5 set if TX was selected. Every other bit keeps the value that was read. A direction that was not selected leaves its bit as read.
- R5: Only when RX was selected, address 0x166 is read and written back with bit 7 = 1 (no rate switch) or 0 (rate switched). All other bits are kept. Without RX, 0x166 is never accessed.
- R6: Address 0x281 is read and written back with bit 5 = RX busy enable and bit 4 = TX busy enable. All other bits are kept.
- R7: The next access writes 0x00000001 to address 0x000 to release the bus.
- R8: After the release, address 0x281 is read with at least `poll_interval` idle cycles between status reads. When bit 1 (RX busy, counted only if enabled) and bit 0 (TX busy, counted only if enabled) both read 0, `done` pulses for one cycle and `busy` drops.
- R9: If the cycles since start reach `timeout_limit` (which must be above zero) while the block waits for the arbitration bit or for the status flags, `error` pulses for one cycle, the block returns to idle with no bus access in flight, and `done` is not raised.
- R10: A `start` pulse is ignored while `busy` is high. A `start` pulse with neither RX nor TX selected is ignored and makes no bus access.
- R11: After reset, `bus_read`, `bus_write`, `busy`, `done` and `error` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle request to run a recalibration |
| opt_rx | input | 1 | Recalibrate the receive path |
| opt_tx | input | 1 | Recalibrate the transmit path |
| opt_rate_switched | input | 1 | A data-rate switch with a new CDR bandwidth took place |
| opt_busy_rx_en | input | 1 | Enable the RX calibration-busy indication |
| opt_busy_tx_en | input | 1 | Enable the TX calibration-busy indication |
| poll_interval | input | 16 | Idle cycles between status reads |
| timeout_limit | input | 24 | Cycle budget for the waiting phases, counted from start |
| bus_addr | output | 12 | Register address |
| bus_read | output | 1 | Read strobe |
| bus_write | output | 1 | Write strobe |
| bus_wdata | output | 32 | Write data |
| bus_rdata | input | 32 | Read data, valid when `bus_waitreq` is low |
| bus_waitreq | input | 1 | Slave stall; the access is held while high |
| busy | output | 1 | A recalibration sequence is running |
| done | output | 1 | One-cycle pulse when calibration completes |
| error | output | 1 | One-cycle pulse on timeout |

## Verification
The assertions assume that the slave eventually lowers `bus_waitreq` for every access, and that `start` and its options are driven with a clean level after reset. They also assume that `timeout_limit` is non-zero and held steady during a run. The bench's register model answers every access after a pseudo-random number of stall cycles and keeps the limit fixed for each run. It changes the options only by pulsing `start`, including one deliberate pulse during a run. The bench also checks the handshake stability on its own at the ports, so a stall-hold fault is caught by the bench's checks independently of the embedded properties.

// File: rtl/recal_pkg.sv
// Package: shared register addresses, bit positions and the sequencer state type.
// Assumes a register bus with 12-bit word addresses and 32-bit data.
package recal_pkg;
    localparam logic [15:0] ADR_OWNER  = 16'h000;
    localparam logic [15:0] ADR_CAL_EN = 16'h100;
    localparam logic [15:0] ADR_RATE   = 16'h166;
    localparam logic [15:0] ADR_CAPST  = 16'h281;

    localparam int BIT_EN_RX      = 1;
    localparam int BIT_EN_TX      = 5;
    localparam int BIT_ADAPT      = 6;
    localparam int BIT_RATE_SAME  = 7;
    localparam int BIT_BUSYEN_RX  = 5;
    localparam int BIT_BUSYEN_TX  = 4;
    localparam int BIT_ARB_HELD   = 2;
    localparam int BIT_ST_RX      = 1;
    localparam int BIT_ST_TX      = 0;

    localparam logic [7:0] OWN_CLAIM   = 8'h02;
    localparam logic [7:0] OWN_RELEASE = 8'h01;

    typedef enum logic [3:0] {
        S_IDLE,
        S_CLAIM,
        S_ARB,
        S_EN_RD,
        S_EN_WR,
        S_RATE_RD,
        S_RATE_WR,
        S_CAP_RD,
        S_CAP_WR,
        S_RELEASE,
        S_GAP,
        S_STAT
    } seq_state_t;
endpackage

// File: rtl/recal_bus_master.sv
// Module: runs one register-bus access at a time with a wait-request handshake.
// Assumes req is only raised when no access is in flight; ack pulses one cycle
// after the completing edge, and rd_q then holds the captured read data.
module recal_bus_master #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              waitreq,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rd_q
);
    logic in_flight;
    assign in_flight = bus_read | bus_write;

    // Launch, hold and retire the single outstanding access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_addr  <= '0;
            bus_read  <= 1'b0;
            bus_write <= 1'b0;
            bus_wdata <= '0;
            ack       <= 1'b0;
            rd_q      <= '0;
        end else begin
            ack <= 1'b0;
            if (in_flight) begin
                if (!waitreq) begin
                    bus_read  <= 1'b0;
                    bus_write <= 1'b0;
                    ack       <= 1'b1;
                    if (bus_read) begin
                        rd_q <= rdata;
                    end
                end
            end else if (req) begin
                bus_addr  <= req_addr;
                bus_wdata <= req_wdata;
                bus_read  <= !req_wr;
                bus_write <= req_wr;
            end
        end
    end

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && waitreq) |=> ($stable(bus_addr) && $stable(bus_wdata) && $stable(bus_read) && $stable(bus_write))); // R1
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_read && bus_write)); // R1
    AST_ACK_FOLLOWS_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_flight && !waitreq) |=> (ack && !bus_read && !bus_write)); // R1
endmodule

// File: rtl/recal_timer.sv
// Module: poll-spacing down-counter and a saturating timeout counter.
// Assumes clr is held while the sequencer is idle; timeout_limit is non-zero.
module recal_timer #(
    parameter int POLL_W = 16,
    parameter int TO_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic              poll_load,
    input  logic [POLL_W-1:0] poll_interval,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic              poll_due,
    output logic              timed_out
);
    logic [POLL_W-1:0] poll_cnt;
    logic [TO_W-1:0]   run_cnt;

    assign poll_due  = (poll_cnt == '0) && !poll_load;
    assign timed_out = (run_cnt >= timeout_limit);

    // Count down the spacing before the next status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            poll_cnt <= '0;
        end else if (poll_load) begin
            poll_cnt <= poll_interval;
        end else if (poll_cnt != '0) begin
            poll_cnt <= poll_cnt - 1'b1;
        end
    end

    // Count cycles since start, stopping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            run_cnt <= '0;
        end else if (run && !timed_out) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_TIMEOUT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (timed_out && !clr && $stable(timeout_limit)) |=> timed_out); // R9
endmodule

// File: rtl/xcvr_recal_seq.sv
// Module: top of the recalibration sequencer. Claims the register bus, waits
// for the grant, applies the read-modify-write steps, releases the bus and
// polls status until the enabled busy flags clear or the time budget runs out.
// Assumes the slave ends each access eventually and the options are valid with start.
module xcvr_recal_seq
    import recal_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int POLL_W = 16,
    parameter int TO_W   = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              opt_rx,
    input  logic              opt_tx,
    input  logic              opt_rate_switched,
    input  logic              opt_busy_rx_en,
    input  logic              opt_busy_tx_en,
    input  logic [POLL_W-1:0] poll_interval,
    input  logic [TO_W-1:0]   timeout_limit,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_read,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_waitreq,
    output logic              busy,
    output logic              done,
    output logic              error
);
    localparam logic [ADDR_W-1:0] A_OWNER  = ADDR_W'(ADR_OWNER);
    localparam logic [ADDR_W-1:0] A_CAL_EN = ADDR_W'(ADR_CAL_EN);
    localparam logic [ADDR_W-1:0] A_RATE   = ADDR_W'(ADR_RATE);
    localparam logic [ADDR_W-1:0] A_CAPST  = ADDR_W'(ADR_CAPST);

    seq_state_t        state;
    logic              pend;
    logic              cfg_rx, cfg_tx, cfg_rs, cfg_brx, cfg_btx;
    logic              req, req_wr, acc_state, ack;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] req_wdata, rd_q;
    logic [DATA_W-1:0] en_val, rate_val, cap_val;
    logic              flags_busy, waiting, stop_to;
    logic              poll_load, poll_due, timed_out;

    assign busy = (state != S_IDLE);

    // Merge the selected fields into the value just read.
    always_comb begin
        en_val                 = rd_q;
        en_val[BIT_ADAPT]      = 1'b0;
        if (cfg_rx) en_val[BIT_EN_RX] = 1'b1;
        if (cfg_tx) en_val[BIT_EN_TX] = 1'b1;
        rate_val               = rd_q;
        rate_val[BIT_RATE_SAME] = !cfg_rs;
        cap_val                = rd_q;
        cap_val[BIT_BUSYEN_RX] = cfg_brx;
        cap_val[BIT_BUSYEN_TX] = cfg_btx;
    end

    assign flags_busy = (rd_q[BIT_ST_RX] & cfg_brx) | (rd_q[BIT_ST_TX] & cfg_btx);
    assign waiting    = (state == S_ARB) || (state == S_GAP) || (state == S_STAT);
    assign stop_to    = waiting && timed_out && !pend;

    // Pick the access that the current state needs.
    always_comb begin
        acc_state = 1'b1;
        req_wr    = 1'b0;
        req_addr  = A_CAPST;
        req_wdata = '0;
        unique case (state)
            S_CLAIM:   begin req_wr = 1'b1; req_addr = A_OWNER; req_wdata = DATA_W'(OWN_CLAIM); end
            S_ARB:     req_addr = A_CAPST;
            S_EN_RD:   req_addr = A_CAL_EN;
            S_EN_WR:   begin req_wr = 1'b1; req_addr = A_CAL_EN; req_wdata = en_val; end
            S_RATE_RD: req_addr = A_RATE;
            S_RATE_WR: begin req_wr = 1'b1; req_addr = A_RATE; req_wdata = rate_val; end
            S_CAP_RD:  req_addr = A_CAPST;
            S_CAP_WR:  begin req_wr = 1'b1; req_addr = A_CAPST; req_wdata = cap_val; end
            S_RELEASE: begin req_wr = 1'b1; req_addr = A_OWNER; req_wdata = DATA_W'(OWN_RELEASE); end
            S_STAT:    req_addr = A_CAPST;
            default:   acc_state = 1'b0;
        endcase
    end

    assign req       = acc_state && !pend && !stop_to;
    assign poll_load = ack && ((state == S_RELEASE) || ((state == S_STAT) && flags_busy));

    // Sequence the steps, latch options, raise done and error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            pend    <= 1'b0;
            done    <= 1'b0;
            error   <= 1'b0;
            cfg_rx  <= 1'b0;
            cfg_tx  <= 1'b0;
            cfg_rs  <= 1'b0;
            cfg_brx <= 1'b0;
            cfg_btx <= 1'b0;
        end else begin
            done  <= 1'b0;
            error <= 1'b0;
            if (req) pend <= 1'b1;
            if (ack) pend <= 1'b0;
            unique case (state)
                S_IDLE: if (start && (opt_rx || opt_tx)) begin
                    cfg_rx  <= opt_rx;
                    cfg_tx  <= opt_tx;
                    cfg_rs  <= opt_rate_switched;
                    cfg_brx <= opt_busy_rx_en;
                    cfg_btx <= opt_busy_tx_en;
                    state   <= S_CLAIM;
                end
                S_CLAIM:   if (ack) state <= S_ARB;
                S_ARB: begin
                    if (stop_to) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end else if (ack && !rd_q[BIT_ARB_HELD]) begin
                        state <= S_EN_RD;
                    end
                end
                S_EN_RD:   if (ack) state <= S_EN_WR;
                S_EN_WR:   if (ack) state <= cfg_rx ? S_RATE_RD : S_CAP_RD;
                S_RATE_RD: if (ack) state <= S_RATE_WR;
                S_RATE_WR: if (ack) state <= S_CAP_RD;
                S_CAP_RD:  if (ack) state <= S_CAP_WR;
                S_CAP_WR:  if (ack) state <= S_RELEASE;
                S_RELEASE: if (ack) state <= S_GAP;
                S_GAP: begin
                    if (stop_to) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end else if (poll_due) begin
                        state <= S_STAT;
                    end
                end
                S_STAT: begin
                    if (stop_to) begin
                        error <= 1'b1;
                        state <= S_IDLE;
                    end else if (ack) begin
                        if (flags_busy) begin
                            state <= S_GAP;
                        end else begin
                            done  <= 1'b1;
                            state <= S_IDLE;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    recal_bus_master #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_master (
        .clk(clk), .rst_n(rst_n), .req(req), .req_wr(req_wr),
        .req_addr(req_addr), .req_wdata(req_wdata), .waitreq(bus_waitreq),
        .rdata(bus_rdata), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .ack(ack), .rd_q(rd_q)
    );

    recal_timer #(.POLL_W(POLL_W), .TO_W(TO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE), .run(busy),
        .poll_load(poll_load), .poll_interval(poll_interval),
        .timeout_limit(timeout_limit), .poll_due(poll_due), .timed_out(timed_out)
    );

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R9
    AST_RATE_NEEDS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_write && bus_addr == A_RATE) |-> cfg_rx); // R5
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({cfg_rx, cfg_tx, cfg_rs, cfg_brx, cfg_btx})); // R10
    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (done || error) |-> (!busy && !bus_read && !bus_write)); // R8
endmodule

// File: tb/xcvr_recal_seq_bench.sv
module xcvr_recal_seq_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        opt_rx = 1'b0, opt_tx = 1'b0, opt_rate_switched = 1'b0;
    logic        opt_busy_rx_en = 1'b0, opt_busy_tx_en = 1'b0;
    logic [15:0] poll_interval = 16'd0;
    logic [23:0] timeout_limit = 24'd50000;
    logic [11:0] bus_addr;
    logic        bus_read, bus_write, bus_waitreq;
    logic [31:0] bus_wdata, bus_rdata;
    logic        busy, done, error;

    always #5 clk = ~clk;

    xcvr_recal_seq u_xcvr_recal_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .opt_rx(opt_rx), .opt_tx(opt_tx),
        .opt_rate_switched(opt_rate_switched), .opt_busy_rx_en(opt_busy_rx_en),
        .opt_busy_tx_en(opt_busy_tx_en), .poll_interval(poll_interval),
        .timeout_limit(timeout_limit), .bus_addr(bus_addr), .bus_read(bus_read),
        .bus_write(bus_write), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_waitreq(bus_waitreq), .busy(busy), .done(done), .error(error)
    );

    int total = 0, bad = 0;

    // register model of the slave
    localparam logic [31:0] INIT_EN   = 32'h8A3C_904C;
    localparam logic [31:0] INIT_RATE = 32'h0F0F_00A5;
    localparam logic [31:0] INIT_CAP  = 32'h5A5A_F0C8;
    logic [31:0] m_en, m_rate, m_cap;
    int   arb_left = 0, st_left = 0, arb_n = 0, st_n = 0;
    logic released = 1'b0, stall_mode = 1'b0;
    logic [7:0] lfsr = 8'h5B;

    assign bus_waitreq = stall_mode && (lfsr[0] || lfsr[3]);

    always_comb begin
        case (bus_addr)
            12'h100: bus_rdata = m_en;
            12'h166: bus_rdata = m_rate;
            12'h281: bus_rdata = {m_cap[31:3], arb_left != 0,
                                  released && st_left != 0, released && st_left != 0};
            default: bus_rdata = 32'hDEAD_0000;
        endcase
    end

    // log of completed accesses
    logic        lg_wr[64];
    logic [11:0] lg_addr[64];
    logic [31:0] lg_data[64];
    longint      lg_cyc[64];
    logic        lg_rel[64];
    int          n_log = 0;
    longint      cyc = 0;
    int          hold_viol = 0, done_cnt = 0, err_cnt = 0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        if ((bus_read || bus_write) && !bus_waitreq) begin
            if (n_log < 64) begin
                lg_wr[n_log]   = bus_write;
                lg_addr[n_log] = bus_addr;
                lg_data[n_log] = bus_write ? bus_wdata : bus_rdata;
                lg_cyc[n_log]  = cyc;
                lg_rel[n_log]  = released;
                n_log = n_log + 1;
            end
            if (bus_write) begin
                case (bus_addr)
                    12'h000: if (bus_wdata == 32'h2) begin arb_left <= arb_n; released <= 1'b0; end
                             else if (bus_wdata == 32'h1) begin released <= 1'b1; st_left <= st_n; end
                    12'h100: m_en <= bus_wdata;
                    12'h166: m_rate <= bus_wdata;
                    12'h281: m_cap <= bus_wdata;
                    default: ;
                endcase
            end else if (bus_addr == 12'h281) begin
                if (!released && arb_left > 0) arb_left <= arb_left - 1;
                if (released && st_left > 0) st_left <= st_left - 1;
            end
        end
    end

    logic p_rd = 1'b0, p_wr = 1'b0, p_wait = 1'b0;
    logic [11:0] p_addr = '0;
    logic [31:0] p_wdata = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_wait && (p_rd || p_wr) &&
                (bus_read != p_rd || bus_write != p_wr || bus_addr != p_addr || bus_wdata != p_wdata))
                hold_viol = hold_viol + 1;
            if (bus_read && bus_write) hold_viol = hold_viol + 1;
            if (done) done_cnt = done_cnt + 1;
            if (error) err_cnt = err_cnt + 1;
        end
        p_rd = bus_read; p_wr = bus_write; p_wait = bus_waitreq;
        p_addr = bus_addr; p_wdata = bus_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // expected access list
    logic        e_wr[64];
    logic [11:0] e_addr[64];
    logic [31:0] e_data[64];
    int          n_exp;
    task automatic push(input logic wr, input logic [11:0] a, input logic [31:0] d);
        e_wr[n_exp] = wr; e_addr[n_exp] = a; e_data[n_exp] = d; n_exp++;
    endtask

    task automatic prep(input int arbs, input int sts, input bit stall);
        @(negedge clk);
        m_en = INIT_EN; m_rate = INIT_RATE; m_cap = INIT_CAP;
        arb_n = arbs; st_n = sts; stall_mode = stall; released = 1'b0;
        arb_left = 0; st_left = 0;
        n_log = 0; done_cnt = 0; err_cnt = 0; hold_viol = 0;
    endtask

    task automatic launch(input bit rx, input bit tx, input bit rs, input bit brx, input bit btx);
        @(negedge clk);
        opt_rx = rx; opt_tx = tx; opt_rate_switched = rs;
        opt_busy_rx_en = brx; opt_busy_tx_en = btx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end(input bit poke_mid);
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (poke_mid && i == 12) begin
                opt_rx = ~opt_rx; opt_tx = 1'b1; opt_rate_switched = ~opt_rate_switched;
                opt_busy_rx_en = ~opt_busy_rx_en; start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if ((done_cnt + err_cnt) > 0 && !busy) break;
        end
        repeat (3) @(negedge clk);
    endtask

    // full sequence scenario, checked against the expected access list
    task automatic run_ok(input string tag, input bit rx, input bit tx, input bit rs,
                          input bit brx, input bit btx, input int arbs, input int sts,
                          input int gap, input bit stall, input bit poke_mid);
        logic [31:0] capr;
        int nstat;
        longint last;
        prep(arbs, sts, stall);
        poll_interval = 16'(gap); timeout_limit = 24'd50000;
        n_exp = 0;
        push(1, 12'h000, 32'h2);                                            // R2
        for (int i = 0; i <= arbs; i++) push(0, 12'h281, 32'h0);            // R3
        push(0, 12'h100, 32'h0);
        push(1, 12'h100, (INIT_EN & ~32'h40) | (32'(rx) << 1) | (32'(tx) << 5)); // R4
        if (rx) begin
            push(0, 12'h166, 32'h0);
            push(1, 12'h166, (INIT_RATE & ~32'h80) | (32'(!rs) << 7));     // R5
        end
        capr = {INIT_CAP[31:3], 3'b000};
        push(0, 12'h281, 32'h0);
        push(1, 12'h281, (capr & ~32'h30) | (32'(brx) << 5) | (32'(btx) << 4)); // R6
        push(1, 12'h000, 32'h1);                                            // R7
        nstat = (brx || btx) ? sts + 1 : 1;
        for (int i = 0; i < nstat; i++) push(0, 12'h281, 32'h0);            // R8
        launch(rx, tx, rs, brx, btx);
        wait_end(poke_mid);
        chk(n_log == n_exp, "R3", {tag, " access count"}, n_log, n_exp);
        for (int i = 0; i < n_exp && i < n_log; i++) begin
            chk(lg_wr[i] == e_wr[i] && lg_addr[i] == e_addr[i], "R4", {tag, " access kind/addr"},
                {lg_wr[i], lg_addr[i]}, {e_wr[i], e_addr[i]});
            if (e_wr[i])
                chk(lg_data[i] == e_data[i], "R6", {tag, " write data"}, lg_data[i], e_data[i]);
        end
        last = -1;
        for (int i = 0; i < n_log; i++) begin
            if (lg_rel[i] && !lg_wr[i]) begin
                if (last >= 0)
                    chk(lg_cyc[i] - last >= gap + 1, "R8", {tag, " status spacing"}, lg_cyc[i] - last, gap + 1);
                last = lg_cyc[i];
            end
        end
        chk(done_cnt == 1 && err_cnt == 0, "R8", {tag, " done pulse"}, {done_cnt, err_cnt}, 64'h1_0000_0000);
        chk(!busy, "R8", {tag, " busy low"}, busy, 0);
        chk(hold_viol == 0, "R1", {tag, " handshake hold"}, hold_viol, 0);
    endtask

    task automatic run_timeout(input string tag, input int arbs, input int sts);
        prep(arbs, sts, 1'b1);
        poll_interval = 16'd3; timeout_limit = 24'd400;
        launch(1, 1, 0, 1, 1);
        wait_end(0);
        chk(err_cnt == 1, "R9", {tag, " error pulse"}, err_cnt, 1);
        chk(done_cnt == 0, "R9", {tag, " no done"}, done_cnt, 0);
        chk(!busy && !bus_read && !bus_write, "R9", {tag, " idle after timeout"},
            {busy, bus_read, bus_write}, 0);
        chk(hold_viol == 0, "R1", {tag, " handshake hold"}, hold_viol, 0);
    endtask

    task automatic run_noop();
        prep(0, 0, 1'b0);
        launch(0, 0, 1, 1, 1);
        repeat (20) @(negedge clk);
        chk(n_log == 0 && !busy && done_cnt == 0, "R10", "start without direction ignored",
            {n_log, busy}, 0);
    endtask

    task automatic run_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!bus_read && !bus_write && !busy && !done && !error, "R11", "reset outputs",
            {bus_read, bus_write, busy, done, error}, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        run_reset();
        run_ok("rxtx", 1, 1, 0, 1, 1, 3, 4, 5, 0, 0);
        run_ok("rx_rateswitch_stall", 1, 0, 1, 1, 0, 2, 3, 0, 1, 0);
        run_ok("tx_only_R5_skip", 0, 1, 0, 0, 1, 1, 2, 20, 1, 0);
        run_ok("no_busy_enables", 1, 0, 0, 0, 0, 0, 5, 4, 0, 0);
        run_ok("R10_start_while_busy", 1, 0, 0, 1, 0, 4, 2, 6, 0, 1);
        run_noop();
        run_timeout("R9_status_stuck", 1, 1000000);
        run_timeout("R9_grant_stuck", 1000000, 1);
        run_ok("recover_after_timeout", 0, 1, 1, 1, 1, 0, 1, 2, 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule